// File: doc/BRIEF.md
# Modem Line Watcher

This block builds the modem-status byte of a 16550-style serial port. It watches four incoming handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It shows their present levels in the upper half of the byte. In the lower half it keeps sticky change flags, and those flags raise a modem-status interrupt request. Each external line first passes through a flop synchroniser. Only then is it compared with its previous value.

When the loopback control is set, the pins are ignored. The four modem-control outputs of the port feed the watcher instead. This lets software test the status path without a cable. A read strobe from the register file tells the block that software has read the status byte. The flags then clear, but a change that lands in the same cycle as the read is kept.

Top module: `modem_line_watch`

## Requirements
- R1: After reset, `stat_q` is 0x00 and `irq_req` is low.
- R2: `stat_q` bits 7, 6, 5 and 4 show the present levels of carrier detect, ring indicator, data-set-ready and clear-to-send, in that bit order. A 1 means the line is asserted.
- R3: `stat_q` bit 0 sets on any change of clear-to-send. Bit 1 sets on any change of data-set-ready. Bit 3 sets on any change of carrier detect.
- R4: `stat_q` bit 2 sets only when ring indicator goes from 1 to 0. A rise of ring indicator leaves it clear.
- R5: While `mc_loop` is 1, the sources are remapped: `mc_rts` drives clear-to-send, `mc_dtr` drives data-set-ready, `mc_out1` drives ring indicator and `mc_out2` drives carrier detect. The pins have no effect in this mode. Each source reaches the status byte one clock edge after it changes.
- R6: With `mc_loop` at 0, a pin change shows in `stat_q` after exactly SYNC_STAGES+1 rising edges, and not before.
- R7: A cycle with `rd_stb` high clears bits 3:0 at the next edge. Bits 7:4 are not affected.
- R8: A change that is detected in the same cycle as `rd_stb` leaves its flag set after that edge.
- R9: `irq_req` is high exactly while any of `stat_q` bits 3:0 is set.
- R10: A set flag stays set until a read, so that changes accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_cts | input | 1 | Clear-to-send line, asynchronous, 1 = asserted |
| pin_dsr | input | 1 | Data-set-ready line, asynchronous |
| pin_ri | input | 1 | Ring indicator line, asynchronous |
| pin_dcd | input | 1 | Carrier detect line, asynchronous |
| mc_rts | input | 1 | Request-to-send output of the modem-control register |
| mc_dtr | input | 1 | Data-terminal-ready output of the modem-control register |
| mc_out1 | input | 1 | Spare output 1 of the modem-control register |
| mc_out2 | input | 1 | Spare output 2 of the modem-control register |
| mc_loop | input | 1 | Loopback select |
| rd_stb | input | 1 | Status register read strobe, one cycle wide |
| stat_q | output | 8 | Modem-status byte |
| irq_req | output | 1 | Modem-status interrupt request |

## Verification
The bench uses the default SYNC_STAGES of 2. That makes the pin-to-status delay three edges, short enough to step through one edge at a time, so the bench can show the value is stale after two edges and correct after the third. Loopback has a single-edge path, which lets the bench line up a source change exactly with a read strobe and check the same-cycle rule. Switching loopback on and off while the pins hold other levels shows that the remapping itself produces change flags.

// File: rtl/mlw_pkg.sv
package mlw_pkg;
  localparam int LINES   = 4;
  localparam int IX_CTS  = 0;
  localparam int IX_DSR  = 1;
  localparam int IX_RI   = 2;
  localparam int IX_DCD  = 3;

  // Change events between the previous and present line levels.
  // Ring indicator counts only on a fall from 1 to 0.
  function automatic logic [LINES-1:0] mlw_events(input logic [LINES-1:0] prev,
                                                  input logic [LINES-1:0] now);
    logic [LINES-1:0] ev;
    ev         = prev ^ now;
    ev[IX_RI]  = prev[IX_RI] & ~now[IX_RI];
    return ev;
  endfunction

  function automatic logic [2*LINES-1:0] mlw_pack(input logic [LINES-1:0] lvl,
                                                  input logic [LINES-1:0] flg);
    return {lvl, flg};
  endfunction
endpackage

// File: rtl/mlw_sync.sv
module mlw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mlw_src_sel.sv
module mlw_src_sel #(
  parameter int W = 4
) (
  input  logic         loop_en,
  input  logic [W-1:0] from_pins,
  input  logic [W-1:0] from_ctrl,
  output logic [W-1:0] lvl_now
);
  always_comb begin
    if (loop_en) lvl_now = from_ctrl;
    else         lvl_now = from_pins;
  end
endmodule

// File: rtl/mlw_delta.sv
module mlw_delta
  import mlw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl_now,
  input  logic             clr,
  output logic [LINES-1:0] lvl_q,
  output logic [LINES-1:0] flg_q,
  output logic [LINES-1:0] evt
);
  assign evt = mlw_events(lvl_q, lvl_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      flg_q <= '0;
    end else begin
      lvl_q <= lvl_now;
      flg_q <= (flg_q & ~{LINES{clr}}) | evt;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_chk
    // R3
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_q[i]) |-> $past(evt[i]));
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt[i]) |=> !flg_q[i]);
    // R8
    flag_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && evt[i]) |=> flg_q[i]);
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[i] && !clr) |=> flg_q[i]);
  end
endmodule

// File: rtl/modem_line_watch.sv
module modem_line_watch
  import mlw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_cts,
  input  logic       pin_dsr,
  input  logic       pin_ri,
  input  logic       pin_dcd,
  input  logic       mc_rts,
  input  logic       mc_dtr,
  input  logic       mc_out1,
  input  logic       mc_out2,
  input  logic       mc_loop,
  input  logic       rd_stb,
  output logic [7:0] stat_q,
  output logic       irq_req
);
  logic [LINES-1:0] pins_raw, pins_sync, ctrl_lines, lvl_now, lvl_q, flg_q, evt;

  assign pins_raw   = {pin_dcd, pin_ri, pin_dsr, pin_cts};
  assign ctrl_lines = {mc_out2, mc_out1, mc_dtr, mc_rts};

  mlw_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_sync));

  mlw_src_sel #(.W(LINES)) u_sel (
    .loop_en(mc_loop), .from_pins(pins_sync), .from_ctrl(ctrl_lines), .lvl_now(lvl_now));

  mlw_delta u_delta (
    .clk(clk), .rst_n(rst_n), .lvl_now(lvl_now), .clr(rd_stb),
    .lvl_q(lvl_q), .flg_q(flg_q), .evt(evt));

  assign stat_q  = mlw_pack(lvl_q, flg_q);
  assign irq_req = |flg_q;

  // R4
  ri_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[2]) |-> ($past(stat_q[6]) && !stat_q[6]));
  // R5
  loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mc_loop) |-> (stat_q[7:4] == $past({mc_out2, mc_out1, mc_dtr, mc_rts})));
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(|evt));
  // R7
  level_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && $stable(lvl_now)) |=> $stable(stat_q[7:4]));
endmodule

// File: tb/modem_line_watch_bench.sv
`timescale 1ns/1ps
module modem_line_watch_bench;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pins = '0;   // {dcd, ri, dsr, cts}
  logic [3:0] mc   = '0;   // {out2, out1, dtr, rts}
  logic loop_en = 1'b0;
  logic rd = 1'b0;
  logic [7:0] stat;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  modem_line_watch #(.SYNC_STAGES(SYNC)) u_modem_line_watch (
    .clk(clk), .rst_n(rst_n),
    .pin_cts(pins[0]), .pin_dsr(pins[1]), .pin_ri(pins[2]), .pin_dcd(pins[3]),
    .mc_rts(mc[0]), .mc_dtr(mc[1]), .mc_out1(mc[2]), .mc_out2(mc[3]),
    .mc_loop(loop_en), .rd_stb(rd), .stat_q(stat), .irq_req(irq));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // {clear_first, loop, pins[3:0], mc[3:0], expected stat[7:0]}
  localparam logic [17:0] VEC [12] = '{
    {1'b1, 1'b0, 4'b0001, 4'b0000, 8'h11},  // R2 R3 cts rise
    {1'b1, 1'b0, 4'b0011, 4'b0000, 8'h32},  // R3 dsr rise
    {1'b1, 1'b0, 4'b0111, 4'b0000, 8'h70},  // R4 ri rise no flag
    {1'b1, 1'b0, 4'b0011, 4'b0000, 8'h34},  // R4 ri fall
    {1'b1, 1'b0, 4'b1011, 4'b0000, 8'hB8},  // R3 dcd rise
    {1'b1, 1'b0, 4'b0000, 4'b0000, 8'h0B},  // R3 falls
    {1'b1, 1'b1, 4'b1111, 4'b0000, 8'h00},  // R5 pins ignored
    {1'b1, 1'b1, 4'b1111, 4'b0101, 8'h51},  // R5 rts, out1
    {1'b1, 1'b1, 4'b1111, 4'b1110, 8'hEB},  // R5 dtr, out2
    {1'b1, 1'b1, 4'b1111, 4'b1010, 8'hA4},  // R5 R4 out1 fall
    {1'b1, 1'b0, 4'b1111, 4'b1010, 8'hF1},  // R5 leave loopback
    {1'b0, 1'b0, 4'b0000, 4'b1010, 8'h0F}   // R10 accumulate
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset stat", stat, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[v]) begin
      if (VEC[v][17]) begin
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
      end
      loop_en = VEC[v][16];
      pins    = VEC[v][15:12];
      mc      = VEC[v][11:8];
      repeat (SYNC + 2) @(negedge clk);
      chk($sformatf("R2-vector %0d", v), stat, VEC[v][7:0]);
      chk($sformatf("R9 irq vector %0d", v), {7'd0, irq}, {7'd0, |VEC[v][3:0]});
    end

    // R7 read clears flags, levels kept; R9 irq drops
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R7 read clear", stat, 8'h00);
    chk("R9 irq low", {7'd0, irq}, 8'h00);

    // R6 synchroniser latency
    pins = 4'b0001;
    repeat (SYNC) @(negedge clk);
    chk("R6 not before", stat, 8'h00);
    @(negedge clk);
    chk("R6 on time", stat, 8'h11);

    // R8 change in same cycle as read
    loop_en = 1'b1;
    mc = 4'b0001;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R7 clear in loop", stat, 8'h10);
    mc = 4'b0000;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R8 race kept", stat, 8'h01);
    chk("R9 irq race", {7'd0, irq}, 8'h01);

    // R5 loop source reaches status after one edge
    mc = 4'b1000;
    @(negedge clk);
    chk("R5 one edge", stat, 8'h89);

    summary();
    $finish;
  end
endmodule